// File: doc/BRIEF.md
# Flash Program/Erase Completion Status Reporter

This block sits in the read path of a flash array controller. While the embedded program or erase engine holds its busy flag, the block replaces array data with a status word on reads. The host can tell that the operation has finished in two independent ways: by a polled bit that reflects the data being written, and by a bit that changes on every read access. When busy falls, reads return the array word unchanged.

Read accesses are taken from two active-low strobes, chip select and output enable. The strobes are sampled on the block clock. An access ends when the combined strobe, which is the OR of the two, goes from low to high. Each completed access flips the toggle bit once, so a cycle on either strobe counts as one access. The erase timer, the program timer and the array are outside the block. The array word arrives on `array_data_i`, already selected by address. The polling address therefore has no path into the status bits.

Top module: `flash_poll_status`

## Requirements
- R1: While `busy_i`=1 and `op_erase_i`=0 (word program), `rd_data_o[7]` equals the inverse of `last_data_i[7]`.
- R2: While `busy_i`=1 and `op_erase_i`=1 (erase), `rd_data_o[7]` is 0 whatever `last_data_i` holds.
- R3: While busy, `rd_data_o[6]` changes once for each completed read access. An access completes when `ce_ni|oe_ni` rises. A cycle on `oe_ni` with `ce_ni` held low counts, and so does a cycle on `ce_ni` with `oe_ni` held low.
- R4: While busy, `rd_data_o[6]` holds its value when no access completes, including while both strobes stay low for many cycles.
- R5: While `busy_i`=0, `rd_data_o` equals `array_data_i` on all bits, and read accesses have no effect on it. This includes the state right after reset.
- R6: While busy, every bit of `rd_data_o` other than 7 and 6 is 0, whatever `array_data_i` holds.
- R7: When `busy_i` rises, the toggle bit is cleared. It reads 0 in the following cycle, even if the previous operation left it at 1.
- R8: The first read after an operation starts already returns valid status, with the bit 7 value of R1 or R2 and a bit 6 of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| busy_i | input | 1 | High while an embedded program or erase runs |
| op_erase_i | input | 1 | Operation kind: 1 erase, 0 word program |
| last_data_i | input | DATA_W | Word most recently loaded for programming |
| ce_ni | input | 1 | Chip select read strobe, active low |
| oe_ni | input | 1 | Output enable read strobe, active low |
| array_data_i | input | DATA_W | Array word at the current read address |
| rd_data_o | output | DATA_W | Status word while busy, array word otherwise |

## Verification
The bench uses strobe patterns in which only one of the two strobes cycles. A design that took edges of a single strobe, or that counted both the fall and the rise of an access, would then lose toggles or double them. Both strobes are also held low for a long stretch, which catches a toggle driven by the clock rather than by accesses. An operation is restarted while the toggle sits at 1, which exposes a missing clear at start. Reads continue after busy falls, which exposes a toggle or polled bit that leaks into array data. The vectors also feed array words with every bit set during busy, which catches status bits that are not forced to zero.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;
  typedef enum logic {
    OP_PROG  = 1'b0,
    OP_ERASE = 1'b1
  } op_kind_e;

  localparam int unsigned DEF_DATA_W   = 16;
  localparam int unsigned DEF_POLL_BIT = 7;
  localparam int unsigned DEF_TGL_BIT  = 6;
endpackage

// File: rtl/fps_access_detect.sv
module fps_access_detect #(
  parameter int unsigned SYNC_STAGES = 0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic oe_ni,
  output logic access_done_o
);
  logic strb_raw;
  logic strb;
  logic strb_q;

  assign strb_raw = ce_ni | oe_ni;

  generate
    if (SYNC_STAGES == 0) begin : g_direct
      assign strb = strb_raw;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[SYNC_STAGES-1:0], strb_raw} >> 0;
      end
      assign strb = sync_q[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strb_q <= 1'b1;
    else         strb_q <= strb;
  end

  // end of access: combined strobe leaves its active level
  assign access_done_o = strb & ~strb_q;
endmodule

// File: rtl/fps_toggle.sv
module fps_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic access_done_i,
  output logic tgl_o
);
  logic busy_q;
  logic op_start;

  assign op_start = busy_i & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      tgl_o  <= 1'b0;
    end else begin
      busy_q <= busy_i;
      if (op_start)                   tgl_o <= 1'b0;
      else if (busy_i && access_done_i) tgl_o <= ~tgl_o;
    end
  end
endmodule

// File: rtl/fps_status_mux.sv
module fps_status_mux
  import flash_stat_pkg::*;
#(
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter int unsigned POLL_BIT = DEF_POLL_BIT,
  parameter int unsigned TGL_BIT  = DEF_TGL_BIT
) (
  input  logic              busy_i,
  input  op_kind_e          op_i,
  input  logic [DATA_W-1:0] last_data_i,
  input  logic [DATA_W-1:0] array_data_i,
  input  logic              tgl_i,
  output logic [DATA_W-1:0] data_o
);
  localparam logic [DATA_W-1:0] POLL_MASK = DATA_W'(1) << POLL_BIT;

  logic [DATA_W-1:0] status;
  logic              unused_data;

  assign unused_data = ^(last_data_i & ~POLL_MASK);

  always_comb begin
    status           = '0;
    status[POLL_BIT] = (op_i == OP_ERASE) ? 1'b0 : ~last_data_i[POLL_BIT];
    status[TGL_BIT]  = tgl_i;
    data_o           = busy_i ? status : array_data_i;
  end
endmodule

// File: rtl/flash_poll_status.sv
module flash_poll_status
  import flash_stat_pkg::*;
#(
  parameter int unsigned DATA_W      = DEF_DATA_W,
  parameter int unsigned POLL_BIT    = DEF_POLL_BIT,
  parameter int unsigned TGL_BIT     = DEF_TGL_BIT,
  parameter int unsigned SYNC_STAGES = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              op_erase_i,
  input  logic [DATA_W-1:0] last_data_i,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic [DATA_W-1:0] array_data_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic     access_done;
  logic     tgl;
  op_kind_e op_kind;

  assign op_kind = op_erase_i ? OP_ERASE : OP_PROG;

  fps_access_detect #(.SYNC_STAGES(SYNC_STAGES)) u_detect (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ce_ni        (ce_ni),
    .oe_ni        (oe_ni),
    .access_done_o(access_done)
  );

  fps_toggle u_toggle (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .busy_i       (busy_i),
    .access_done_i(access_done),
    .tgl_o        (tgl)
  );

  fps_status_mux #(
    .DATA_W  (DATA_W),
    .POLL_BIT(POLL_BIT),
    .TGL_BIT (TGL_BIT)
  ) u_mux (
    .busy_i      (busy_i),
    .op_i        (op_kind),
    .last_data_i (last_data_i),
    .array_data_i(array_data_i),
    .tgl_i       (tgl),
    .data_o      (rd_data_o)
  );
endmodule

// File: rtl/fps_checker.sv
module fps_checker #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned POLL_BIT = 7,
  parameter int unsigned TGL_BIT  = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_i,
  input logic              op_erase_i,
  input logic [DATA_W-1:0] last_data_i,
  input logic [DATA_W-1:0] array_data_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              access_done_i
);
  localparam logic [DATA_W-1:0] STAT_MASK =
    (DATA_W'(1) << POLL_BIT) | (DATA_W'(1) << TGL_BIT);

  a_r1_prog_poll: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !op_erase_i) |-> rd_data_o[POLL_BIT] == ~last_data_i[POLL_BIT]);

  a_r2_erase_poll: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && op_erase_i) |-> !rd_data_o[POLL_BIT]);

  a_r3_toggle_on_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && access_done_i && !$rose(busy_i))
      |=> (!busy_i || rd_data_o[TGL_BIT] != $past(rd_data_o[TGL_BIT])));

  a_r4_toggle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !access_done_i && !$rose(busy_i))
      |=> (!busy_i || $stable(rd_data_o[TGL_BIT])));

  a_r5_idle_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> rd_data_o == array_data_i);

  a_r6_other_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (rd_data_o & ~STAT_MASK) == '0);

  a_r7_start_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |=> (!busy_i || !rd_data_o[TGL_BIT]));
endmodule

bind flash_poll_status fps_checker #(
  .DATA_W  (DATA_W),
  .POLL_BIT(POLL_BIT),
  .TGL_BIT (TGL_BIT)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_i       (busy_i),
  .op_erase_i   (op_erase_i),
  .last_data_i  (last_data_i),
  .array_data_i (array_data_i),
  .rd_data_o    (rd_data_o),
  .access_done_i(access_done)
);

// File: tb/flash_poll_status_tb.sv
module flash_poll_status_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        busy = 1'b0;
  logic        erase = 1'b0;
  logic [15:0] last = '0;
  logic        ce_n = 1'b1;
  logic        oe_n = 1'b1;
  logic [15:0] arr = 16'h5A5A;
  logic [15:0] rd;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  flash_poll_status u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .busy_i      (busy),
    .op_erase_i  (erase),
    .last_data_i (last),
    .ce_ni       (ce_n),
    .oe_ni       (oe_n),
    .array_data_i(arr),
    .rd_data_o   (rd)
  );

  typedef struct packed {
    logic        busy;
    logic        erase;
    logic [15:0] last;
    logic [15:0] arr;
    logic [15:0] exp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b1, 1'b0, 16'h0080, 16'hFFFF, 16'h0000},
    '{1'b1, 1'b0, 16'h0000, 16'hFFFF, 16'h0080},
    '{1'b1, 1'b1, 16'h00FF, 16'hFFFF, 16'h0000},
    '{1'b1, 1'b1, 16'h0000, 16'h1234, 16'h0000},
    '{1'b0, 1'b0, 16'h0080, 16'hA5C3, 16'hA5C3},
    '{1'b0, 1'b1, 16'h0000, 16'h00C0, 16'h00C0},
    '{1'b1, 1'b0, 16'hFF7F, 16'h0000, 16'h0080},
    '{1'b0, 1'b0, 16'h0000, 16'hFFFF, 16'hFFFF}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic start_op(input logic er, input logic [15:0] d);
    @(negedge clk) busy = 1'b0;
    @(negedge clk) begin busy = 1'b1; erase = er; last = d; end
    @(negedge clk);
  endtask

  task automatic rd_both(output logic [15:0] v);
    @(negedge clk) begin ce_n = 1'b0; oe_n = 1'b0; end
    @(negedge clk) begin v = rd; ce_n = 1'b1; oe_n = 1'b1; end
    @(negedge clk);
  endtask

  task automatic rd_ce_only(output logic [15:0] v);
    @(negedge clk) oe_n = 1'b0;
    @(negedge clk) ce_n = 1'b0;
    @(negedge clk) begin v = rd; ce_n = 1'b1; end
    @(negedge clk) oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd_oe_only(output logic [15:0] v);
    @(negedge clk) ce_n = 1'b0;
    @(negedge clk) oe_n = 1'b0;
    @(negedge clk) begin v = rd; oe_n = 1'b1; end
    @(negedge clk) ce_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] r;
    logic [15:0] prev;
    logic [15:0] s0;

    repeat (3) @(negedge clk);
    check("R5 reset", rd, 16'h5A5A);
    rst_n = 1'b1;

    for (int i = 0; i < 8; i++) begin
      if (VECS[i].busy) start_op(VECS[i].erase, VECS[i].last);
      else begin
        @(negedge clk) begin busy = 1'b0; erase = VECS[i].erase; last = VECS[i].last; end
      end
      arr = VECS[i].arr;
      @(negedge clk);
      check(VECS[i].busy ? (VECS[i].erase ? "R2/R6 vec" : "R1/R6 vec") : "R5 vec",
            rd, VECS[i].exp);
    end

    // R8: first read after start, program of a word with bit7 clear
    arr = 16'hFFFF;
    start_op(1'b0, 16'h0055);
    rd_both(r);
    check("R8 first read", r, 16'h0080);
    rd_both(r);
    check("R3 second read", r, 16'h00C0);
    rd_ce_only(r);
    check("R3 ce-only access", r, 16'h0080);
    rd_oe_only(r);
    check("R3 oe-only access", r, 16'h00C0);
    prev = 16'h00C0;
    for (int k = 0; k < 6; k++) begin
      rd_both(r);
      check("R3 consecutive reads differ", {15'd0, r[6] ^ prev[6]}, 16'd1);
      prev = r;
    end

    // R4: long access without an end
    @(negedge clk) begin ce_n = 1'b0; oe_n = 1'b0; end
    @(negedge clk) s0 = rd;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check("R4 held strobe", rd, s0);
    end
    @(negedge clk) begin ce_n = 1'b1; oe_n = 1'b1; end
    repeat (3) @(negedge clk);
    check("R4 idle no access", rd, s0 ^ 16'h0040);

    // R7: restart while toggle is 1
    rd_both(r);
    if (r[6]) rd_both(r);
    start_op(1'b1, 16'hFFFF);
    rd_both(r);
    check("R7/R2 cleared at start", r, 16'h0000);
    rd_both(r);
    check("R3 erase toggle", r, 16'h0040);

    // R5: after completion
    @(negedge clk) begin busy = 1'b0; arr = 16'h0040; end
    for (int k = 0; k < 3; k++) begin
      rd_both(r);
      check("R5 done, no toggle", r, 16'h0040);
    end
    arr = 16'h3C81;
    @(negedge clk);
    check("R5 done pass-through", rd, 16'h3C81);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule